// File: doc/BRIEF.md
# Single-Bus Hardwired Processor Core

This block is a small processor core built around one shared internal bus. Every instruction runs as a fixed, numbered series of bus transfers. Each step moves one source onto the bus, loads one or more registers from it, and may add through a single adder. The core holds a program counter, a memory address register, a memory data register, an instruction register, an ALU operand register Y, an ALU result register Z, a negative flag N and four general registers.

A step sequencer drives seven one-hot step lines, T1 to T7. An instruction decoder drives one-hot instruction lines. A hardwired control matrix forms every control signal as an OR of step-and-instruction products.

The sequencer is a state machine with the states ST_T1 to ST_T7. It has four transitions:
- advance: ST_Tk goes to ST_Tk+1 when the step is neither stalled nor finishing.
- hold: any state stays where it is while the step waits for memory and completion has not arrived.
- finish: any state returns to ST_T1 when the step asserts the end signal and is not stalled.
- reset: the machine goes to ST_T1.

Memory is reached through an address output, a read request and a read data input. A memory-function-complete pulse ends each access. Two observation outputs carry the internal bus value and the step lines.

Top module: `sbus_cpu`

## Requirements
- R1: Reset sets the program counter, Z, Y, N, the instruction register and all general registers to zero, and sets the step to T1. The first fetch therefore reads address 0, and the bus carries 0 during reset.
- R2: The fetch takes steps T1 to T3. T1 puts PC on the bus, loads MAR, requests a read and loads Z with PC+4. T2 moves Z into PC and Y and waits for memory. T3 moves MDR into IR. Sequential fetch addresses step by 4 bytes.
- R3: In a step that waits for memory, the step holds until the completion pulse arrives. A pending read keeps the read request and the address stable until that pulse.
- R4: Register add (opcode bits [31:28]=1, destination bits [27:26], source bits [25:24]) sets the destination to destination+source modulo 2^32. It ends at T6, so the instruction takes 6 steps plus memory waits.
- R5: Indirect add (opcode 2) puts the source register on the address output at T4. It adds the word read there to the destination register and ends at T7.
- R6: Direct load (opcode 3, destination bits [27:26]) reads the address formed by IR bits [24:0] padded with zeros. It writes the word read into the destination and ends at T6.
- R7: Branch (opcode 4) sets PC to the branch address + 4 + the sign-extended offset in bits [15:0]. It ends at T5.
- R8: Branch-if-negative (opcode 5) behaves as R7 when N is 1. When N is 0 it ends at T4 and the next fetch is at the branch address + 4.
- R9: N takes the sign bit of each sum loaded into Z in steps T4 to T7. The PC increment at T1 leaves N unchanged.
- R10: Exactly one step line is active at all times, and a finishing step is followed by T1. Any other opcode ends at T4 with no effect beyond the fetch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_addr | output | 32 | Memory address (MAR contents) |
| mem_rd | output | 1 | Read request, high from the request until the completion pulse |
| mem_rdata | input | 32 | Read data, taken when mem_mfc is high |
| mem_mfc | input | 1 | Memory-function-complete pulse |
| bus_mon | output | 32 | Value on the internal bus |
| step_mon | output | 7 | One-hot step lines, bit 0 is T1 |

## Verification
The assertions check on every cycle the following properties:
- exactly one step line is active;
- a waiting step holds until completion;
- a pending read keeps its address;
- every finish returns to T1;
- the fetch step loads MAR with PC and Z with PC+4;
- the fetch step leaves N alone;
- no two sources drive the bus together.

Only the bench's programs can show that the arithmetic results, the load and indirect addresses, and the branch targets are right. They also show the taken and fall-through choice under N, and the per-instruction step counts seen as gaps between fetches, under several memory latencies.

// File: rtl/sbus_cpu_pkg.sv
package sbus_cpu_pkg;

    localparam int NSTEP = 7;

    typedef enum logic [2:0] {
        ST_T1 = 3'd0,
        ST_T2 = 3'd1,
        ST_T3 = 3'd2,
        ST_T4 = 3'd3,
        ST_T5 = 3'd4,
        ST_T6 = 3'd5,
        ST_T7 = 3'd6
    } step_e;

    localparam logic [3:0] OP_ADD    = 4'd1;
    localparam logic [3:0] OP_ADDIND = 4'd2;
    localparam logic [3:0] OP_LOAD   = 4'd3;
    localparam logic [3:0] OP_BR     = 4'd4;
    localparam logic [3:0] OP_BRN    = 4'd5;

    // one-hot instruction lines
    typedef struct packed {
        logic other;
        logic brn;
        logic br;
        logic load;
        logic addind;
        logic add;
    } ins_t;

    // control word driven by the hardwired matrix
    typedef struct packed {
        logic pc_out;
        logic pc_in;
        logic mar_in;
        logic read;
        logic mdr_out;
        logic ir_in;
        logic y_in;
        logic z_in;
        logic z_out;
        logic sel4;
        logic n_upd;
        logic src_out;
        logic dst_out;
        logic dst_in;
        logic off_out;
        logic addr_out;
        logic wmfc;
        logic fin;
    } ctl_t;

endpackage

// File: rtl/sbus_step_seq.sv
module sbus_step_seq
    import sbus_cpu_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stall,
    input  logic             fin,
    output step_e            step,
    output logic [NSTEP-1:0] step_oh
);

    step_e step_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) step <= ST_T1;
        else        step <= step_nx;
    end

    always_comb begin
        step_nx = step;
        if (stall) begin
            step_nx = step;
        end else if (fin) begin
            step_nx = ST_T1;
        end else begin
            unique case (step)
                ST_T1:   step_nx = ST_T2;
                ST_T2:   step_nx = ST_T3;
                ST_T3:   step_nx = ST_T4;
                ST_T4:   step_nx = ST_T5;
                ST_T5:   step_nx = ST_T6;
                ST_T6:   step_nx = ST_T7;
                ST_T7:   step_nx = ST_T1;
                default: step_nx = ST_T1;
            endcase
        end
    end

    for (genvar i = 0; i < NSTEP; i++) begin : g_line
        assign step_oh[i] = (step == step_e'(i));
    end

    p_step_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(step_oh));

    p_stall_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> $stable(step_oh));

    p_fin_t1_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (fin && !stall) |=> step_oh[0]);

endmodule

// File: rtl/sbus_ins_dec.sv
module sbus_ins_dec
    import sbus_cpu_pkg::*;
(
    input  logic [3:0] opcode,
    output ins_t       ins
);

    always_comb begin
        ins = '0;
        unique case (opcode)
            OP_ADD:    ins.add    = 1'b1;
            OP_ADDIND: ins.addind = 1'b1;
            OP_LOAD:   ins.load   = 1'b1;
            OP_BR:     ins.br     = 1'b1;
            OP_BRN:    ins.brn    = 1'b1;
            default:   ins.other  = 1'b1;
        endcase
    end

endmodule

// File: rtl/sbus_ctl_matrix.sv
module sbus_ctl_matrix
    import sbus_cpu_pkg::*;
(
    input  logic [NSTEP-1:0] step_oh,
    input  ins_t             ins,
    input  logic             n_flag,
    output ctl_t             ctl
);

    logic t1, t2, t3, t4, t5, t6, t7;
    logic any_br;

    assign t1 = step_oh[0];
    assign t2 = step_oh[1];
    assign t3 = step_oh[2];
    assign t4 = step_oh[3];
    assign t5 = step_oh[4];
    assign t6 = step_oh[5];
    assign t7 = step_oh[6];
    assign any_br = ins.br | ins.brn;

    // each signal is a sum of step-and-instruction products
    always_comb begin
        ctl          = '0;
        ctl.pc_out   = t1;
        ctl.sel4     = t1;
        ctl.mar_in   = t1 | (t4 & (ins.addind | ins.load));
        ctl.read     = t1 | (t4 & (ins.addind | ins.load));
        ctl.z_in     = t1 | (t5 & ins.add) | (t6 & ins.addind) | (t4 & any_br);
        ctl.n_upd    = (t5 & ins.add) | (t6 & ins.addind) | (t4 & any_br);
        ctl.z_out    = t2 | (t6 & ins.add) | (t7 & ins.addind) | (t5 & any_br);
        ctl.pc_in    = t2 | (t5 & any_br);
        ctl.y_in     = t2 | (t4 & ins.add) | (t5 & ins.addind);
        ctl.wmfc     = t2 | (t5 & (ins.addind | ins.load));
        ctl.mdr_out  = t3 | (t6 & (ins.addind | ins.load));
        ctl.ir_in    = t3;
        ctl.src_out  = t4 & (ins.add | ins.addind);
        ctl.dst_out  = t5 & (ins.add | ins.addind);
        ctl.dst_in   = (t6 & ins.add) | (t7 & ins.addind) | (t6 & ins.load);
        ctl.off_out  = t4 & any_br;
        ctl.addr_out = t4 & ins.load;
        ctl.fin      = (t6 & ins.add) | (t7 & ins.addind) | (t6 & ins.load)
                     | (t5 & any_br) | (t4 & ins.brn & ~n_flag)
                     | (t4 & ins.other);
    end

endmodule

// File: rtl/sbus_datapath.sv
module sbus_datapath
    import sbus_cpu_pkg::*;
#(
    parameter int DW   = 32,
    parameter int NREG = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  ctl_t          ctl,
    input  logic [DW-1:0] mem_rdata,
    input  logic          mem_mfc,
    output logic [DW-1:0] mem_addr,
    output logic          mem_rd,
    output logic [DW-1:0] bus,
    output logic [3:0]    opcode,
    output logic          n_flag,
    output logic          stall
);

    localparam int RW      = $clog2(NREG);
    localparam int DST_LSB = 26;
    localparam int SRC_LSB = 24;
    localparam int OFF_W   = 16;
    localparam int ADR_W   = 25;

    logic [DW-1:0] pc, mar, mdr, ir, y, z;
    logic [DW-1:0] gpr [NREG];
    logic [DW-1:0] alu_a, alu_sum;
    logic [RW-1:0] dst_sel, src_sel;
    logic          rd_pend;

    assign opcode  = ir[DW-1 -: 4];
    assign dst_sel = ir[DST_LSB +: RW];
    assign src_sel = ir[SRC_LSB +: RW];

    // single bus: one source per step
    always_comb begin
        bus = '0;
        if (ctl.pc_out)   bus = pc;
        if (ctl.z_out)    bus = z;
        if (ctl.mdr_out)  bus = mdr;
        if (ctl.off_out)  bus = {{(DW-OFF_W){ir[OFF_W-1]}}, ir[OFF_W-1:0]};
        if (ctl.addr_out) bus = {{(DW-ADR_W){1'b0}}, ir[ADR_W-1:0]};
        if (ctl.src_out)  bus = gpr[src_sel];
        if (ctl.dst_out)  bus = gpr[dst_sel];
    end

    assign alu_a   = ctl.sel4 ? DW'(4) : y;
    assign alu_sum = alu_a + bus;
    assign stall   = ctl.wmfc & rd_pend & ~mem_mfc;
    assign mem_addr = mar;
    assign mem_rd   = rd_pend;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc     <= '0;
            mar    <= '0;
            ir     <= '0;
            y      <= '0;
            z      <= '0;
            n_flag <= 1'b0;
        end else begin
            if (ctl.pc_in)  pc  <= bus;
            if (ctl.mar_in) mar <= bus;
            if (ctl.ir_in)  ir  <= bus;
            if (ctl.y_in)   y   <= bus;
            if (ctl.z_in)   z   <= alu_sum;
            if (ctl.n_upd)  n_flag <= alu_sum[DW-1];
        end
    end

    // read request and memory data register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_pend <= 1'b0;
            mdr     <= '0;
        end else begin
            if (rd_pend && mem_mfc) begin
                rd_pend <= 1'b0;
                mdr     <= mem_rdata;
            end
            if (ctl.read) rd_pend <= 1'b1;
        end
    end

    for (genvar r = 0; r < NREG; r++) begin : g_gpr
        always_ff @(posedge clk) begin
            if (!rst_n)                                   gpr[r] <= '0;
            else if (ctl.dst_in && dst_sel == RW'(r))     gpr[r] <= bus;
        end
    end

    p_bus_one_driver_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ctl.pc_out, ctl.z_out, ctl.mdr_out, ctl.off_out,
                  ctl.addr_out, ctl.src_out, ctl.dst_out}));

    p_fetch_inc_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.pc_out && ctl.sel4 && ctl.z_in) |=>
            (z == $past(pc) + DW'(4)) && (mar == $past(pc)));

    p_n_keep_fetch_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.sel4 |=> (n_flag == $past(n_flag)));

    p_read_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_pend && !mem_mfc) |=> (rd_pend && $stable(mar)));

endmodule

// File: rtl/sbus_cpu.sv
module sbus_cpu
    import sbus_cpu_pkg::*;
#(
    parameter int DW   = 32,
    parameter int NREG = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [DW-1:0]    mem_addr,
    output logic             mem_rd,
    input  logic [DW-1:0]    mem_rdata,
    input  logic             mem_mfc,
    output logic [DW-1:0]    bus_mon,
    output logic [NSTEP-1:0] step_mon
);

    step_e            step;
    logic [NSTEP-1:0] step_oh;
    ins_t             ins;
    ctl_t             ctl;
    logic [3:0]       opcode;
    logic             n_flag;
    logic             stall;

    sbus_step_seq u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .stall   (stall),
        .fin     (ctl.fin),
        .step    (step),
        .step_oh (step_oh)
    );

    sbus_ins_dec u_dec (
        .opcode (opcode),
        .ins    (ins)
    );

    sbus_ctl_matrix u_ctl (
        .step_oh (step_oh),
        .ins     (ins),
        .n_flag  (n_flag),
        .ctl     (ctl)
    );

    sbus_datapath #(.DW(DW), .NREG(NREG)) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl       (ctl),
        .mem_rdata (mem_rdata),
        .mem_mfc   (mem_mfc),
        .mem_addr  (mem_addr),
        .mem_rd    (mem_rd),
        .bus       (bus_mon),
        .opcode    (opcode),
        .n_flag    (n_flag),
        .stall     (stall)
    );

    assign step_mon = step_oh;

    p_step_enum_r10: assert property (@(posedge clk) disable iff (!rst_n)
        step_mon[step]);

endmodule

// File: tb/sbus_cpu_bench.sv
`timescale 1ns/1ps
module sbus_cpu_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] mem_addr, mem_rdata, bus_mon;
    logic        mem_rd, mem_mfc;
    logic [6:0]  step_mon;

    always #2.5 clk = ~clk;

    sbus_cpu u_sbus_cpu (
        .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rd(mem_rd),
        .mem_rdata(mem_rdata), .mem_mfc(mem_mfc),
        .bus_mon(bus_mon), .step_mon(step_mon)
    );

    logic [31:0] mem [64];
    int lat = 0;
    int wcnt = 0;

    // memory with programmable latency
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_mfc   <= 1'b0;
            mem_rdata <= '0;
            wcnt      <= 0;
        end else if (mem_rd && !mem_mfc) begin
            if (wcnt >= lat) begin
                mem_mfc   <= 1'b1;
                mem_rdata <= mem[mem_addr[7:2]];
                wcnt      <= 0;
            end else begin
                wcnt <= wcnt + 1;
            end
        end else begin
            mem_mfc <= 1'b0;
        end
    end

    int ntot = 0, nbad = 0, cyc = 0, nlog = 0;
    logic rd_q = 1'b0;
    logic [31:0] log_a [64];
    int          log_t [64];

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (rst_n && mem_rd && !rd_q && nlog < 64) begin
            log_a[nlog] = mem_addr;
            log_t[nlog] = cyc;
            nlog = nlog + 1;
        end
        rd_q = mem_rd;
        if (cyc > 100000) begin
            ntot = ntot + 1;
            nbad = nbad + 1;
            $display("FAIL watchdog: act=%0d exp<=100000 cycles", cyc);
            $display("  test done: total=%0d bad=%0d", ntot, nbad);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        ntot = ntot + 1;
        if (!ok) begin
            nbad = nbad + 1;
            $display("FAIL %s: act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] op_rr(input logic [3:0] op, input int d,
                                          input int s, input int off);
        logic [31:0] w;
        w = {op, 2'(d), 2'(s), 8'h00, 16'(off)};
        return w;
    endfunction

    function automatic logic [31:0] op_ld(input int d, input logic [24:0] a);
        return {4'd3, 2'(d), 1'b0, a};
    endfunction

    task automatic clear_mem();
        for (int i = 0; i < 64; i++) mem[i] = '0;
    endtask

    task automatic run(input int latency, input int cycles);
        lat = latency;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        nlog = 0;
        rst_n = 1'b1;
        repeat (cycles) @(negedge clk);
    endtask

    // a, b, expected sum, memory latency
    localparam logic [127:0] VEC [4] = '{
        {32'h0000_0005, 32'h0000_0007, 32'h0000_000C, 32'd0},
        {32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0000, 32'd2},
        {32'h1234_5678, 32'h1111_1111, 32'h2345_6789, 32'd1},
        {32'h7FFF_FFFF, 32'h0000_0001, 32'h8000_0000, 32'd4}
    };

    initial begin
        // R1: reset state
        clear_mem();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check(step_mon == 7'b0000001, "R1 step", 32'(step_mon), 32'h1);
        check(bus_mon == 32'h0, "R1 bus", bus_mon, 32'h0);

        // table: load, load, add, indirect probe, self loop
        for (int v = 0; v < 4; v++) begin
            clear_mem();
            mem[0]  = op_ld(1, 25'h80);
            mem[1]  = op_ld(2, 25'h84);
            mem[2]  = op_rr(4'd1, 1, 2, 0);
            mem[3]  = op_rr(4'd2, 0, 1, 0);
            mem[4]  = op_rr(4'd4, 0, 0, -4);
            mem[32] = VEC[v][127:96];
            mem[33] = VEC[v][95:64];
            run(int'(VEC[v][31:0]), 200);
            check(log_a[0] == 32'h0, "R1 first fetch", log_a[0], 32'h0);
            check(log_a[1] == 32'h80, "R6 load addr", log_a[1], 32'h80);
            check(log_a[2] == 32'h4, "R2 next fetch", log_a[2], 32'h4);
            check(log_a[6] == VEC[v][63:32], "R4 sum", log_a[6], VEC[v][63:32]);
            check(log_a[7] == 32'h10, "R7 loop fetch", log_a[7], 32'h10);
        end

        // R5 indirect add
        clear_mem();
        mem[0]  = op_ld(1, 25'h80);
        mem[1]  = op_ld(3, 25'h84);
        mem[2]  = op_rr(4'd2, 1, 3, 0);
        mem[3]  = op_rr(4'd2, 0, 1, 0);
        mem[4]  = op_rr(4'd4, 0, 0, -4);
        mem[32] = 32'd5;
        mem[33] = 32'h90;
        mem[36] = 32'd7;
        run(1, 200);
        check(log_a[5] == 32'h90, "R5 indirect addr", log_a[5], 32'h90);
        check(log_a[7] == 32'hC, "R5 indirect sum", log_a[7], 32'hC);

        // R7 forward and backward branch
        clear_mem();
        mem[0] = op_rr(4'd4, 0, 0, 8);
        mem[3] = op_rr(4'd4, 0, 0, -12);
        mem[1] = op_rr(4'd4, 0, 0, -4);
        run(0, 100);
        check(log_a[1] == 32'hC, "R7 forward", log_a[1], 32'hC);
        check(log_a[2] == 32'h4, "R7 backward", log_a[2], 32'h4);
        check(log_a[3] == 32'h4, "R7 self", log_a[3], 32'h4);
        check(log_t[2] - log_t[1] == 6, "R7 length", 32'(log_t[2] - log_t[1]), 32'd6);

        // R8 R9 branch-if-negative taken
        clear_mem();
        mem[0]  = op_ld(1, 25'h80);
        mem[1]  = op_rr(4'd1, 1, 0, 0);
        mem[2]  = op_rr(4'd5, 0, 0, 8);
        mem[3]  = op_rr(4'd4, 0, 0, -4);
        mem[5]  = op_rr(4'd4, 0, 0, -4);
        mem[32] = 32'h8000_0000;
        run(0, 150);
        check(log_a[4] == 32'h14, "R8 R9 taken", log_a[4], 32'h14);
        check(log_t[3] - log_t[2] == 7, "R4 length", 32'(log_t[3] - log_t[2]), 32'd7);
        check(log_t[4] - log_t[3] == 6, "R8 taken length", 32'(log_t[4] - log_t[3]), 32'd6);

        // R8 not taken
        mem[32] = 32'd5;
        run(0, 150);
        check(log_a[4] == 32'hC, "R8 fall through", log_a[4], 32'hC);
        check(log_t[4] - log_t[3] == 5, "R8 short length", 32'(log_t[4] - log_t[3]), 32'd5);

        // R10 unknown opcode acts as a four-step no-op
        clear_mem();
        mem[0] = 32'hF000_0000;
        mem[1] = op_rr(4'd4, 0, 0, -4);
        run(0, 60);
        check(log_a[1] == 32'h4, "R10 other opcode", log_a[1], 32'h4);
        check(log_t[1] - log_t[0] == 5, "R10 other length", 32'(log_t[1] - log_t[0]), 32'd5);

        // R3 latency stretches the fetch wait
        run(6, 100);
        check(log_t[1] - log_t[0] == 11, "R3 stall", 32'(log_t[1] - log_t[0]), 32'd11);

        $display("  test done: total=%0d bad=%0d", ntot, nbad);
        $finish;
    end

endmodule